// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the command front end of a parallel NOR-style flash, written as a clocked model. It samples the active-low chip enable, write enable and output enable strobes, a data-width select, the address bus and the data bus. It decodes multi-write unlock sequences into program, erase, identification and fast-program commands. It then hands program and erase jobs to a separate array/algorithm stub through single-cycle request pulses.

The read path has three sources. Array data comes from the stub. Identification codes come from two parameters. Status bits are returned while a job is running. Which source is used depends on the decoder state, not on the address. Unlock data and addresses, command codes, identification codes, the sector count and the multi-sector collection window are all parameters.

A job ends when the stub pulses `alg_done`. Until then the decoder reports busy and discards every write except the suspend command.

Top module: `flash_cmd_if`

## Requirements
- R1: A write is taken once per strobe, on the first clock where `ce_n` and `we_n` are both low with `oe_n` high; holding the strobe for more cycles does not repeat it, and a strobe made while `oe_n` is low is not a write.
- R2: The writes AA@555, 55@2AA, A0@555 followed by one data write give one `prog_req` pulse carrying that write's address and data, and `busy` goes high on the same clock.
- R3: With `wide`=1, program data is all of `din[15:0]` and array reads return the 16-bit word. With `wide`=0, only `din[7:0]` is taken (upper byte zero) and array reads return the byte chosen by `addr[0]` (0 selects the low byte, 1 the high byte), zero-extended. `prog_wide` reports the width used for the program.
- R4: The writes AA@555, 55@2AA, 20@555 enter the fast-program state. There, A0 at any address followed by a data write starts a program, and the decoder goes back to the fast-program state when the job ends.
- R5: The writes AA@555, 55@2AA, 90@555 enter identification mode. Reads then return the manufacturer code 0x01 when `addr[1:0]`=0, the device code 0x5B when it is 1, and 0 otherwise, all in the low byte. Writes other than F0 leave this mode unchanged.
- R6: Writing F0 in identification mode or in the fast-program state returns the decoder to array reads.
- R7: The writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 30 at an address, start a sector erase. The sector is `addr[11:10]`, and further 30 writes add sectors. Once ERASE_WIN (8) clocks pass with no write, one `erase_req` pulse carries the mask of the collected sectors.
- R8: A 10@555 write in place of the first 30 gives an `erase_req` whose mask has all sectors set.
- R9: A write that does not match the expected step of a sequence returns the decoder to array reads and issues no request.
- R10: While `busy` is high, reads return status: bit 7 is the inverse of data bit 7 for a program and 0 for an erase, bit 6 changes on every read, and all other bits are 0. `busy` stays high until `alg_done`.
- R11: While `busy` is high, every write except B0 is ignored. B0 at any address gives one `susp_req` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wide | input | 1 | 1 selects 16-bit data, 0 selects 8-bit |
| addr | input | 12 | Address bus |
| din | input | 16 | Write data bus |
| dout | output | 16 | Read data, zero when not driven |
| dout_en | output | 1 | Read data is valid |
| arr_rdata | input | 16 | Array word from the stub at `addr` |
| alg_done | input | 1 | Stub finished the running job |
| busy | output | 1 | A job is running |
| prog_req | output | 1 | One-cycle program request |
| erase_req | output | 1 | One-cycle erase request |
| susp_req | output | 1 | One-cycle suspend request |
| cmd_addr | output | 12 | Program address |
| cmd_data | output | 16 | Program data |
| prog_wide | output | 1 | Width of the requested program |
| erase_mask | output | 4 | Sectors to erase |

## Verification
The assertions rely on three things about the inputs. The strobes are synchronous to `clk`. Address and data stay stable for the whole time a strobe is low. `alg_done` is pulsed only while `busy` is high. The bench meets these by changing inputs only at falling clock edges, opening and closing each strobe as a whole clean cycle, and pulsing `alg_done` once after each expected request.

// File: rtl/flash_cmd_if.sv
module flash_cmd_if #(
  parameter int AW = 12,
  parameter int SB = 2,
  parameter logic [AW-1:0] UNL_A1 = 12'h555,
  parameter logic [AW-1:0] UNL_A2 = 12'h2AA,
  parameter logic [7:0] UNL_D1 = 8'hAA,
  parameter logic [7:0] UNL_D2 = 8'h55,
  parameter logic [7:0] C_PROG = 8'hA0,
  parameter logic [7:0] C_ERASE = 8'h80,
  parameter logic [7:0] C_CHIP = 8'h10,
  parameter logic [7:0] C_SECT = 8'h30,
  parameter logic [7:0] C_AUTO = 8'h90,
  parameter logic [7:0] C_FAST = 8'h20,
  parameter logic [7:0] C_RESET = 8'hF0,
  parameter logic [7:0] C_SUSP = 8'hB0,
  parameter logic [7:0] MFR_ID = 8'h01,
  parameter logic [7:0] DEV_ID = 8'h5B,
  parameter int ERASE_WIN = 8,
  localparam int NSEC = 1 << SB,
  localparam int WW = $clog2(ERASE_WIN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic            wide,
  input  logic [AW-1:0]   addr,
  input  logic [15:0]     din,
  output logic [15:0]     dout,
  output logic            dout_en,
  input  logic [15:0]     arr_rdata,
  input  logic            alg_done,
  output logic            busy,
  output logic            prog_req,
  output logic            erase_req,
  output logic            susp_req,
  output logic [AW-1:0]   cmd_addr,
  output logic [15:0]     cmd_data,
  output logic            prog_wide,
  output logic [NSEC-1:0] erase_mask
);

  typedef enum logic [3:0] {
    S_RD, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3, S_ESEC, S_AS, S_FAST, S_FPGM, S_BUSY
  } st_t;

  st_t st;
  logic wr_q, rd_q, ret_fast, st_d7, tog;
  logic [WW-1:0] win;

  wire wr_act = !ce_n && !we_n && oe_n;
  wire rd_act = !ce_n && !oe_n && we_n;
  wire wr_ev = wr_act && !wr_q;
  wire [7:0] wd = din[7:0];
  wire at_a1 = addr == UNL_A1;
  wire at_a2 = addr == UNL_A2;
  wire [15:0] pdata = wide ? din : {8'h00, din[7:0]};
  wire [NSEC-1:0] sec_bit = NSEC'(1) << addr[AW-1:AW-SB];

  assign busy = st == S_BUSY;
  assign dout_en = rd_act;

  always_comb begin
    dout = 16'h0000;
    if (dout_en) begin
      if (st == S_BUSY)
        dout = {8'h00, st_d7, tog, 6'b0};
      else if (st == S_AS)
        dout = {8'h00, addr[1:0] == 2'd0 ? MFR_ID : addr[1:0] == 2'd1 ? DEV_ID : 8'h00};
      else if (wide)
        dout = arr_rdata;
      else
        dout = {8'h00, addr[0] ? arr_rdata[15:8] : arr_rdata[7:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RD;
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      prog_req <= 1'b0;
      erase_req <= 1'b0;
      susp_req <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
      prog_wide <= 1'b0;
      erase_mask <= '0;
      win <= '0;
      ret_fast <= 1'b0;
      st_d7 <= 1'b0;
      tog <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      prog_req <= 1'b0;
      erase_req <= 1'b0;
      susp_req <= 1'b0;
      if (st == S_BUSY && rd_act && !rd_q) tog <= ~tog;
      case (st)
        S_RD: if (wr_ev && wd == UNL_D1 && at_a1) st <= S_U1;
        S_U1: if (wr_ev) st <= (wd == UNL_D2 && at_a2) ? S_U2 : S_RD;
        S_U2: if (wr_ev) begin
          if (!at_a1) st <= S_RD;
          else if (wd == C_PROG) st <= S_PGM;
          else if (wd == C_ERASE) st <= S_E1;
          else if (wd == C_AUTO) st <= S_AS;
          else if (wd == C_FAST) st <= S_FAST;
          else st <= S_RD;
        end
        S_PGM, S_FPGM: if (wr_ev) begin
          prog_req <= 1'b1;
          cmd_addr <= addr;
          cmd_data <= pdata;
          prog_wide <= wide;
          st_d7 <= ~pdata[7];
          ret_fast <= st == S_FPGM;
          st <= S_BUSY;
        end
        S_E1: if (wr_ev) st <= (wd == UNL_D1 && at_a1) ? S_E2 : S_RD;
        S_E2: if (wr_ev) st <= (wd == UNL_D2 && at_a2) ? S_E3 : S_RD;
        S_E3: if (wr_ev) begin
          if (wd == C_CHIP && at_a1) begin
            erase_req <= 1'b1;
            erase_mask <= '1;
            st_d7 <= 1'b0;
            ret_fast <= 1'b0;
            st <= S_BUSY;
          end else if (wd == C_SECT) begin
            erase_mask <= sec_bit;
            win <= '0;
            st <= S_ESEC;
          end else st <= S_RD;
        end
        S_ESEC: begin
          if (wr_ev) begin
            if (wd == C_SECT) begin
              erase_mask <= erase_mask | sec_bit;
              win <= '0;
            end else st <= S_RD;
          end else if (win == WW'(ERASE_WIN - 1)) begin
            erase_req <= 1'b1;
            st_d7 <= 1'b0;
            ret_fast <= 1'b0;
            st <= S_BUSY;
          end else win <= win + 1'b1;
        end
        S_AS: if (wr_ev && wd == C_RESET) st <= S_RD;
        S_FAST: if (wr_ev) st <= (wd == C_PROG) ? S_FPGM : S_RD;
        S_BUSY: begin
          if (alg_done) st <= ret_fast ? S_FAST : S_RD;
          else if (wr_ev && wd == C_SUSP) susp_req <= 1'b1;
        end
        default: st <= S_RD;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int NSEC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce_n,
  input logic            we_n,
  input logic            oe_n,
  input logic            alg_done,
  input logic            busy,
  input logic            prog_req,
  input logic            erase_req,
  input logic            susp_req,
  input logic            dout_en,
  input logic [15:0]     dout,
  input logic [NSEC-1:0] erase_mask
);

  // R1
  no_strobe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || we_n || !oe_n) |=> (!prog_req && !susp_req));

  // R2
  prog_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> busy);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !alg_done) |=> busy);

  // R10
  status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_en) |-> (dout[15:8] == 8'h00 && dout[5:0] == 6'h00));

  // R11
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, erase_req, susp_req}));

  // R11
  susp_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> $past(busy));

  // R7
  erase_mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> (erase_mask != '0));

endmodule

bind flash_cmd_if flash_cmd_chk #(.NSEC(NSEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .alg_done(alg_done), .busy(busy), .prog_req(prog_req), .erase_req(erase_req),
  .susp_req(susp_req), .dout_en(dout_en), .dout(dout), .erase_mask(erase_mask)
);

// File: tb/sim_flash_cmd_if.sv
`timescale 1ns/1ps
module sim_flash_cmd_if;
  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1, wide = 1, alg_done = 0;
  logic [11:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] arr_rdata = 16'hC3A5;
  logic [15:0] dout, cmd_data;
  logic dout_en, busy, prog_req, erase_req, susp_req, prog_wide;
  logic [11:0] cmd_addr;
  logic [3:0] erase_mask;
  int checks = 0, fails = 0;
  bit ended = 0;
  logic [34:0] exp_q[$];
  string tag_q[$];
  logic [15:0] r1, r2;

  always #2.5 clk = ~clk;

  flash_cmd_if u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .wide(wide),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .arr_rdata(arr_rdata),
    .alg_done(alg_done), .busy(busy), .prog_req(prog_req), .erase_req(erase_req),
    .susp_req(susp_req), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .prog_wide(prog_wide), .erase_mask(erase_mask)
  );

  task automatic chk(string tag, logic [34:0] act, logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(string tag, logic [1:0] kind, logic w, logic [3:0] m, logic [11:0] a, logic [15:0] d);
    exp_q.push_back({kind, w, m, a, d});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && (prog_req || erase_req || susp_req)) begin
      logic [34:0] act;
      if (prog_req) act = {2'd1, prog_wide, 4'd0, cmd_addr, cmd_data};
      else if (erase_req) act = {2'd2, 1'b0, erase_mask, 12'd0, 16'd0};
      else act = {2'd3, 1'b0, 4'd0, 12'd0, 16'd0};
      if (exp_q.size() == 0) chk("R9 unexpected request", act, 35'd0);
      else chk(tag_q.pop_front(), act, exp_q.pop_front());
    end
  end

  task automatic wr(logic [11:0] a, logic [15:0] d, int hold = 1, logic oe = 1);
    @(negedge clk);
    addr = a; din = d; oe_n = oe; ce_n = 0; we_n = 0;
    repeat (hold) @(negedge clk);
    we_n = 1; ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; ce_n = 0; oe_n = 0;
    @(negedge clk);
    v = dout;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic done_pulse();
    @(negedge clk); alg_done = 1;
    @(negedge clk); alg_done = 0;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(12'h555, 16'h00AA);
    wr(12'h2AA, 16'h0055);
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [15:0] e);
    logic [15:0] v;
    rd(a, v);
    chk(tag, {19'd0, v}, {19'd0, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset busy", {34'd0, busy}, 35'd0);
    chk("R1 reset dout_en", {34'd0, dout_en}, 35'd0);
    rd_chk("R3 reset array word", 12'h000, 16'hC3A5);

    // R2 word program and R10 status
    unlock(); wr(12'h555, 16'h00A0);
    push("R2 program", 2'd1, 1'b1, 4'd0, 12'h123, 16'h1234);
    wr(12'h123, 16'h1234);
    chk("R2 busy", {34'd0, busy}, 35'd1);
    rd(12'h123, r1); rd(12'h123, r2);
    chk("R10 status d7", {34'd0, r1[7]}, 35'd1);
    chk("R10 status other bits", {19'd0, r1 & 16'hFFBF}, {19'd0, 16'h0080});
    chk("R10 toggle", {34'd0, r1[6] ^ r2[6]}, 35'd1);
    done_pulse();
    chk("R10 busy clears", {34'd0, busy}, 35'd0);

    // R3 byte program and byte reads
    wide = 0;
    unlock(); wr(12'h555, 16'h00A0);
    push("R3 byte program", 2'd1, 1'b0, 4'd0, 12'h040, 16'h009C);
    wr(12'h040, 16'hAB9C);
    rd(12'h040, r1);
    chk("R10 status d7 byte", {34'd0, r1[7]}, 35'd0);
    done_pulse();
    rd_chk("R3 byte low", 12'h000, 16'h00A5);
    rd_chk("R3 byte high", 12'h001, 16'h00C3);
    wide = 1;

    // R1 write with oe low ignored, held strobe counts once
    unlock(); wr(12'h555, 16'h00A0);
    wr(12'h200, 16'h5A5A, 1, 1'b0);
    push("R1 held strobe once", 2'd1, 1'b1, 4'd0, 12'h201, 16'h0F0F);
    wr(12'h201, 16'h0F0F, 4);
    done_pulse();

    // R4 fast program, R6 exit
    unlock(); wr(12'h555, 16'h0020);
    wr(12'h010, 16'h00A0);
    push("R4 fast program 1", 2'd1, 1'b1, 4'd0, 12'h010, 16'h00F0);
    wr(12'h010, 16'h00F0);
    done_pulse();
    wr(12'h777, 16'h00A0);
    push("R4 fast program 2", 2'd1, 1'b1, 4'd0, 12'h011, 16'h0055);
    wr(12'h011, 16'h0055);
    done_pulse();
    wr(12'h000, 16'h00F0);
    wr(12'h555, 16'h00A0);
    wr(12'h012, 16'h7777);
    rd_chk("R6 fast exit array read", 12'h000, 16'hC3A5);

    // R5 identification, R6 exit
    unlock(); wr(12'h555, 16'h0090);
    rd_chk("R5 manufacturer", 12'h000, 16'h0001);
    rd_chk("R5 device", 12'h001, 16'h005B);
    rd_chk("R5 other", 12'h002, 16'h0000);
    wr(12'h555, 16'h00A0);
    rd_chk("R5 write ignored", 12'h004, 16'h0001);
    wr(12'h000, 16'h00F0);
    rd_chk("R6 ident exit", 12'h000, 16'hC3A5);

    // R7 multi-sector erase, R11 busy writes
    unlock(); wr(12'h555, 16'h0080); unlock();
    wr(12'h400, 16'h0030);
    push("R7 sector erase mask", 2'd2, 1'b0, 4'b1010, 12'd0, 16'd0);
    wr(12'hC00, 16'h0030);
    repeat (12) @(negedge clk);
    chk("R7 busy after window", {34'd0, busy}, 35'd1);
    rd(12'h000, r1);
    chk("R10 erase status d7", {34'd0, r1[7]}, 35'd0);
    unlock(); wr(12'h555, 16'h00A0);
    push("R11 suspend", 2'd3, 1'b0, 4'd0, 12'd0, 16'd0);
    wr(12'h300, 16'h00B0);
    done_pulse();
    wr(12'h300, 16'h1111);
    rd_chk("R11 ignored writes", 12'h000, 16'hC3A5);

    // R8 chip erase
    unlock(); wr(12'h555, 16'h0080); unlock();
    push("R8 chip erase", 2'd2, 1'b0, 4'b1111, 12'd0, 16'd0);
    wr(12'h555, 16'h0010);
    done_pulse();

    // R9 broken sequence
    wr(12'h555, 16'h00AA);
    wr(12'h100, 16'h0055);
    wr(12'h555, 16'h00A0);
    wr(12'h050, 16'h2222);
    rd_chk("R9 broken to array", 12'h000, 16'hC3A5);
    unlock(); wr(12'h555, 16'h00A0);
    push("R9 restart works", 2'd1, 1'b1, 4'd0, 12'h051, 16'h3333);
    wr(12'h051, 16'h3333);
    done_pulse();

    repeat (4) @(negedge clk);
    chk("R9 all requests seen", {3'd0, 32'(exp_q.size())}, 35'd0);
    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule